// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block runs single accesses to asynchronous static memories. It drives active-low chip selects, a read strobe and a write strobe, together with address, byte-select and write-data outputs, and it captures read data. An access starts from a one-cycle request on the front-end port. The first access cycle is the clock cycle after the request is sampled. A counter then places every strobe edge using a set of cycle counts. Each chip select has its own read set and its own write set. Each set holds five counts: strobe setup, strobe pulse, chip-select setup, chip-select pulse and total cycle length.

A write-only configuration port loads the counts. When the slow-clock input is high, the block ignores the programmed sets and uses a fixed minimal waveform set that is the same for every chip select. Nothing has to be reprogrammed when the clock slows down. The block samples the slow-clock input, and the set it selects, only when it accepts a request. An access that is already running keeps the timing it started with.

Top module: `smc_strobe_gen`

## Requirements
- R1: After reset, all `mem_cs_n` bits, `mem_rd_n` and `mem_wr_n` are high, and `ack` and `mem_dq_oe` are low.
- R2: In access cycle k (k = 0 is the cycle after the request is accepted), the strobe for the access direction is low exactly when strobe-setup <= k < strobe-setup + strobe-pulse. `mem_rd_n` is used for reads and `mem_wr_n` for writes. The other strobe stays high.
- R3: Only the chip select addressed by the access goes low. It is low exactly when cs-setup <= k < cs-setup + cs-pulse. At most one chip select is low in any cycle.
- R4: The access length is the largest of total, strobe-setup + strobe-pulse and cs-setup + cs-pulse, with a minimum of 1. `ack` is high for exactly one cycle, in the last access cycle.
- R5: With `slow_mode` high at acceptance, a read lasts 2 cycles. The chip select is low in both cycles and `mem_rd_n` is low only in the second cycle.
- R6: With `slow_mode` high at acceptance, a write lasts 3 cycles. The chip select is low in all three cycles and `mem_wr_n` is low only in the second cycle.
- R7: The slow-mode waveforms in R5 and R6 apply to every chip select, whatever has been programmed.
- R8: The block samples `slow_mode` only when it accepts a request. A change of `slow_mode` during an access does not alter that access.
- R9: `mem_addr` carries the request address and `mem_bs_n` carries the inverted byte enables for every cycle of the access. `mem_bs_n` is all ones when idle.
- R10: `mem_dq_oe` is high and `mem_dq_out` holds the write data for every cycle of a write. `rdata` takes `mem_dq_in` at the clock edge where the read strobe rises. A read with zero strobe pulse leaves `rdata` unchanged.
- R11: A configuration write selects the chip select with `cfg_cs` and the set with `cfg_dir` (0 = read set, 1 = write set). `cfg_field` picks the count: 0 strobe setup, 1 strobe pulse, 2 cs setup, 3 cs pulse, 4 total. Codes 5 to 7 change nothing. After reset, every set is 1, 2, 0, 4, 4.
- R12: A request is accepted only while no access is running. A request during an access is ignored, and the next access can begin after one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_mode | input | 1 | Selects the fixed low-speed waveform set |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | CS_W | Chip select whose sets are written |
| cfg_dir | input | 1 | 0 read set, 1 write set |
| cfg_field | input | 3 | Count selector |
| cfg_wdata | input | CNT_W | Count value |
| req | input | 1 | Access request, one cycle |
| req_we | input | 1 | 1 write, 0 read |
| req_cs | input | CS_W | Target chip select |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | High in the last access cycle |
| rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_bs_n | output | BE_W | Active-low byte selects |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DATA_W | Data returned by memory |

## Verification
The hardest case to reach is a change of the slow-clock input, or a stray request, while an access is already running. Nothing at the ports shows which timing set was latched at acceptance. The stimulus therefore flips `slow_mode` in the first access cycle and pulses `req` toward another chip select one cycle later. The expected waveform is still the one for the mode that held at acceptance, and the expected idle cycle that follows would expose any extra access. The memory model drives valid read data only while the read strobe is low, so a capture on the wrong edge returns a wrong value.

// File: rtl/smc_pkg.sv
package smc_pkg;
    parameter int CNT_W = 6;
    localparam int LEN_W = CNT_W + 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        cnt_t stb_setup;
        cnt_t stb_pulse;
        cnt_t sel_setup;
        cnt_t sel_pulse;
        cnt_t total;
    } phase_set_t;

    typedef enum logic [2:0] {
        FLD_STB_SETUP = 3'd0,
        FLD_STB_PULSE = 3'd1,
        FLD_SEL_SETUP = 3'd2,
        FLD_SEL_PULSE = 3'd3,
        FLD_TOTAL     = 3'd4
    } field_e;

    localparam phase_set_t RESET_SET = '{
        stb_setup: cnt_t'(1), stb_pulse: cnt_t'(2),
        sel_setup: cnt_t'(0), sel_pulse: cnt_t'(4),
        total:     cnt_t'(4)
    };

    function automatic phase_set_t slow_set(input logic is_write);
        phase_set_t p;
        p.stb_setup = cnt_t'(1);
        p.stb_pulse = cnt_t'(1);
        p.sel_setup = cnt_t'(0);
        p.sel_pulse = is_write ? cnt_t'(3) : cnt_t'(2);
        p.total     = is_write ? cnt_t'(3) : cnt_t'(2);
        return p;
    endfunction

    function automatic len_t span(input cnt_t a, input cnt_t b);
        return len_t'(a) + len_t'(b);
    endfunction

    function automatic len_t access_len(input phase_set_t p);
        len_t m;
        m = len_t'(p.total);
        if (span(p.stb_setup, p.stb_pulse) > m) m = span(p.stb_setup, p.stb_pulse);
        if (span(p.sel_setup, p.sel_pulse) > m) m = span(p.sel_setup, p.sel_pulse);
        if (m == '0) m = len_t'(1);
        return m;
    endfunction

    function automatic logic in_window(input len_t k, input cnt_t start, input cnt_t width);
        return (k >= len_t'(start)) && (k < span(start, width));
    endfunction

    function automatic phase_set_t apply_field(input phase_set_t p, input logic [2:0] fld,
                                               input cnt_t val);
        phase_set_t r;
        r = p;
        case (fld)
            FLD_STB_SETUP: r.stb_setup = val;
            FLD_STB_PULSE: r.stb_pulse = val;
            FLD_SEL_SETUP: r.sel_setup = val;
            FLD_SEL_PULSE: r.sel_pulse = val;
            FLD_TOTAL:     r.total     = val;
            default:       r = p;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/smc_timing_regs.sv
module smc_timing_regs
    import smc_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [$clog2(NUM_CS)-1:0] cfg_cs,
    input  logic                      cfg_dir,
    input  logic [2:0]                cfg_field,
    input  cnt_t                      cfg_wdata,
    input  logic [$clog2(NUM_CS)-1:0] sel_cs,
    input  logic                      sel_dir,
    output phase_set_t                sel_set
);
    localparam int CS_W = $clog2(NUM_CS);

    phase_set_t rd_bank [NUM_CS];
    phase_set_t wr_bank [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        phase_set_t rd_cell;
        phase_set_t wr_cell;
        logic       hit;

        assign hit = cfg_we && (cfg_cs == CS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_cell <= RESET_SET;
                wr_cell <= RESET_SET;
            end else if (hit) begin
                if (cfg_dir) wr_cell <= apply_field(wr_cell, cfg_field, cfg_wdata);
                else         rd_cell <= apply_field(rd_cell, cfg_field, cfg_wdata);
            end
        end

        assign rd_bank[g] = rd_cell;
        assign wr_bank[g] = wr_cell;
    end

    assign sel_set = sel_dir ? wr_bank[sel_cs] : rd_bank[sel_cs];
endmodule

// File: rtl/smc_access_seq.sv
module smc_access_seq
    import smc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  phase_set_t                tim,
    input  logic                      in_we,
    input  logic [$clog2(NUM_CS)-1:0] in_cs,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic [BE_W-1:0]           in_be,
    input  logic [DATA_W-1:0]         in_wdata,
    input  logic [DATA_W-1:0]         dq_in,
    output logic                      busy,
    output logic                      last,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_CS-1:0]         mem_cs_n,
    output logic                      mem_rd_n,
    output logic                      mem_wr_n,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [BE_W-1:0]           mem_bs_n,
    output logic [DATA_W-1:0]         mem_dq_out,
    output logic                      mem_dq_oe
);
    localparam int CS_W = $clog2(NUM_CS);

    len_t                cnt;
    len_t                cur_len;
    phase_set_t          cur;
    logic                cur_we;
    logic [CS_W-1:0]     cur_cs;
    logic [ADDR_W-1:0]   addr_q;
    logic [BE_W-1:0]     be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                stb_on;
    logic                sel_on;
    logic                capture;

    always_comb begin
        last    = busy && (cnt == cur_len - len_t'(1));
        stb_on  = busy && in_window(cnt, cur.stb_setup, cur.stb_pulse);
        sel_on  = busy && in_window(cnt, cur.sel_setup, cur.sel_pulse);
        capture = stb_on && !cur_we
                  && (cnt == span(cur.stb_setup, cur.stb_pulse) - len_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            cur_len <= len_t'(1);
            cur     <= '0;
            cur_we  <= 1'b0;
            cur_cs  <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                busy    <= 1'b1;
                cnt     <= '0;
                cur     <= tim;
                cur_len <= access_len(tim);
                cur_we  <= in_we;
                cur_cs  <= in_cs;
                addr_q  <= in_addr;
                be_q    <= in_be;
                wdata_q <= in_wdata;
            end else if (busy) begin
                if (last) busy <= 1'b0;
                else      cnt  <= cnt + len_t'(1);
            end
            if (capture) rdata_q <= dq_in;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign mem_cs_n[g] = !(sel_on && (cur_cs == CS_W'(g)));
    end

    assign mem_rd_n   = !(stb_on && !cur_we);
    assign mem_wr_n   = !(stb_on && cur_we);
    assign mem_addr   = addr_q;
    assign mem_bs_n   = busy ? ~be_q : '1;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = busy && cur_we;
    assign rdata      = rdata_q;

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (rst) last |=> !last);
    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~mem_cs_n));
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!mem_rd_n && !mem_wr_n));
    // R8
    set_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> $stable(cur));
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> ($stable(mem_addr) && $stable(mem_bs_n)));
    // R10
    wr_oe_chk: assert property (@(posedge clk) disable iff (rst) !mem_wr_n |-> mem_dq_oe);
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
    import smc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8,
    parameter int CS_W   = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_mode,
    input  logic              cfg_we,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic              cfg_dir,
    input  logic [2:0]        cfg_field,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic              req_we,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    phase_set_t prog_set;
    phase_set_t chosen;
    logic       busy;
    logic       start;

    assign start  = req && !busy;
    assign chosen = slow_mode ? slow_set(req_we) : prog_set;

    smc_timing_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_dir   (cfg_dir),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .sel_cs    (req_cs),
        .sel_dir   (req_we),
        .sel_set   (prog_set)
    );

    smc_access_seq #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tim        (chosen),
        .in_we      (req_we),
        .in_cs      (req_cs),
        .in_addr    (req_addr),
        .in_be      (req_be),
        .in_wdata   (req_wdata),
        .dq_in      (mem_dq_in),
        .busy       (busy),
        .last       (ack),
        .rdata      (rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .mem_addr   (mem_addr),
        .mem_bs_n   (mem_bs_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    // R5
    slow_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (start && slow_mode && !req_we) |=> (mem_rd_n && !ack) ##1 (!mem_rd_n && ack));
    // R6
    slow_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && slow_mode && req_we) |=>
            (mem_wr_n && !ack) ##1 (!mem_wr_n && !ack) ##1 (mem_wr_n && ack));
    // R12
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !busy);
endmodule

// File: tb/tb_smc_strobe_gen.sv
module tb_smc_strobe_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_cs = '0;
    logic        cfg_dir = 1'b0;
    logic [2:0]  cfg_field = '0;
    logic [5:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
    logic [1:0]  mem_bs_n;
    logic [15:0] rpat = 16'h0000;

    // memory model: valid data only while the read strobe is low
    assign mem_dq_in = !mem_rd_n ? rpat : 16'hDEAD;

    smc_strobe_gen dut (
        .clk(clk), .rst(rst), .slow_mode(slow_mode),
        .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_dir(cfg_dir),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_cs(req_cs), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_bs_n(mem_bs_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [3:0]  cs_n;
        logic        rd_n, wr_n, oe, ack;
        logic [1:0]  bs_n;
        logic [15:0] addr, dq;
        logic        chk_addr;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int sh [4][2][5];
    logic [15:0] prev_rd = 16'h0000;
    bit finished = 0;

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({mem_cs_n, mem_rd_n, mem_wr_n, mem_dq_oe, ack, mem_bs_n} !==
                {it.cs_n, it.rd_n, it.wr_n, it.oe, it.ack, it.bs_n}
                || (it.chk_addr && mem_addr !== it.addr)
                || (it.oe && mem_dq_out !== it.dq)) begin
                errors++;
                $display("FAIL %s actual cs_n=%b rd_n=%b wr_n=%b oe=%b ack=%b bs_n=%b addr=%h dq=%h expected cs_n=%b rd_n=%b wr_n=%b oe=%b ack=%b bs_n=%b addr=%h dq=%h",
                    it.tag, mem_cs_n, mem_rd_n, mem_wr_n, mem_dq_oe, ack, mem_bs_n, mem_addr,
                    mem_dq_out, it.cs_n, it.rd_n, it.wr_n, it.oe, it.ack, it.bs_n, it.addr, it.dq);
            end
        end
    end

    task automatic cfg_write(input int cs, input int dir, input int fld, input int val);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_cs = 2'(cs); cfg_dir = dir[0]; cfg_field = 3'(fld);
        cfg_wdata = 6'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (fld < 5) sh[cs][dir][fld] = val; // R11: codes 5..7 change nothing
    endtask

    task automatic do_access(input logic we, input int cs, input logic [15:0] addr,
                             input logic [1:0] be, input logic [15:0] wd,
                             input logic [15:0] pat, input bit flip, input bit poke,
                             input string tag);
        int t[5];
        int len;
        item_t it;
        @(negedge clk); #1;
        if (slow_mode) begin
            // R5 R6 R7: fixed set on any chip select
            t = '{1, 1, 0, (we ? 3 : 2), (we ? 3 : 2)};
        end else begin
            for (int f = 0; f < 5; f++) t[f] = sh[cs][we][f];
        end
        len = t[4];
        if (t[0] + t[1] > len) len = t[0] + t[1];
        if (t[2] + t[3] > len) len = t[2] + t[3];
        if (len == 0) len = 1;
        for (int k = 0; k < len; k++) begin
            logic stb, sel;
            stb = (k >= t[0]) && (k < t[0] + t[1]);
            sel = (k >= t[2]) && (k < t[2] + t[3]);
            it.cs_n = 4'hF;
            if (sel) it.cs_n[cs] = 1'b0;
            it.rd_n = !(stb && !we);
            it.wr_n = !(stb && we);
            it.oe = we;
            it.ack = (k == len - 1);
            it.bs_n = ~be;
            it.addr = addr;
            it.dq = wd;
            it.chk_addr = 1'b1;
            it.tag = tag;
            q.push_back(it);
        end
        it.cs_n = 4'hF; it.rd_n = 1'b1; it.wr_n = 1'b1; it.oe = 1'b0; it.ack = 1'b0;
        it.bs_n = 2'b11; it.chk_addr = 1'b0; it.tag = {tag, " idle R12"};
        q.push_back(it);
        rpat = pat;
        req_we = we; req_cs = 2'(cs); req_addr = addr; req_be = be; req_wdata = wd;
        req = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        if (flip) slow_mode = ~slow_mode; // R8
        if (poke) begin // R12: request during access must be ignored
            @(posedge clk); #1;
            req = 1'b1; req_cs = 2'(cs + 1); req_we = ~we; req_addr = ~addr;
            @(posedge clk); #1;
            req = 1'b0;
            repeat (len - 2) @(posedge clk);
        end else begin
            repeat (len) @(posedge clk);
        end
        #1;
        if (flip) slow_mode = ~slow_mode;
        if (!we) begin
            logic [15:0] exp_rd;
            exp_rd = (t[1] > 0) ? pat : prev_rd; // R10
            checks++;
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL R10 %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
            end
            prev_rd = exp_rd;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < 2; d++) begin
                sh[c][d][0] = 1; sh[c][d][1] = 2; sh[c][d][2] = 0;
                sh[c][d][3] = 4; sh[c][d][4] = 4;
            end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if ({mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_dq_oe} !== 8'b11111100) begin
            errors++;
            $display("FAIL R1 actual=%b expected=%b",
                     {mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_dq_oe}, 8'b11111100);
        end
        // R2 R3 R4 R10: read with stretch to cs span 6
        cfg_write(0, 0, 0, 2); cfg_write(0, 0, 1, 3); cfg_write(0, 0, 2, 0);
        cfg_write(0, 0, 3, 6); cfg_write(0, 0, 4, 4);
        do_access(1'b0, 0, 16'h1234, 2'b11, 16'h0, 16'hA5A5, 0, 0, "R2 R3 R4 cs0 read");
        // R2 R3 R4 R10: write with long total
        cfg_write(1, 1, 0, 1); cfg_write(1, 1, 1, 2); cfg_write(1, 1, 2, 1);
        cfg_write(1, 1, 3, 2); cfg_write(1, 1, 4, 8);
        do_access(1'b1, 1, 16'h4321, 2'b01, 16'hBEEF, 16'h0, 0, 0, "R2 R3 R4 R9 cs1 write");
        // R11 defaults
        do_access(1'b0, 2, 16'h0F0F, 2'b10, 16'h0, 16'h5A5A, 0, 0, "R11 cs2 default read");
        // R11 unused field code 5 ignored
        cfg_write(2, 0, 5, 9);
        do_access(1'b0, 2, 16'h0F10, 2'b11, 16'h0, 16'h1111, 0, 0, "R11 field5 ignored");
        // R4 all zero counts -> one-cycle access
        for (int f = 0; f < 5; f++) cfg_write(3, 1, f, 0);
        do_access(1'b1, 3, 16'h0003, 2'b11, 16'hC0DE, 16'h0, 0, 0, "R4 min length");
        // R10 read with zero pulse leaves rdata
        for (int f = 0; f < 5; f++) cfg_write(3, 0, f, (f == 4) ? 3 : 0);
        do_access(1'b0, 3, 16'h0033, 2'b11, 16'h0, 16'h7777, 0, 0, "R10 zero pulse read");
        // R5 R6 R7 slow mode on several chip selects
        slow_mode = 1'b1;
        do_access(1'b0, 0, 16'h2000, 2'b11, 16'h0, 16'h2222, 0, 0, "R5 R7 slow read cs0");
        do_access(1'b0, 3, 16'h2003, 2'b01, 16'h0, 16'h3333, 0, 0, "R5 R7 slow read cs3");
        do_access(1'b1, 1, 16'h2001, 2'b10, 16'h9999, 16'h0, 0, 0, "R6 R7 slow write cs1");
        do_access(1'b1, 2, 16'h2002, 2'b11, 16'h8888, 16'h0, 0, 0, "R6 R7 slow write cs2");
        // R8 slow to normal flip mid-access plus R12 ignored request
        do_access(1'b1, 1, 16'h3001, 2'b11, 16'h4444, 16'h0, 1, 1, "R8 R12 slow write flip");
        slow_mode = 1'b0;
        do_access(1'b0, 0, 16'h3000, 2'b11, 16'h0, 16'h6666, 1, 1, "R8 R12 normal read flip");
        do_access(1'b1, 1, 16'h3002, 2'b11, 16'h1357, 16'h0, 0, 0, "R2 R9 back to normal");
        repeat (3) @(posedge clk);
        finished = 1;
        report();
    end
endmodule